// File: doc/BRIEF.md
# CAN Error Flag Monitor

This block sits beside the error counters and the receive-buffer loader of a CAN node. It compares the receive and transmit error counters against fixed limits. From those limits it keeps warning flags, error-passive flags and a bus-off flag. It also keeps one sticky overflow bit per receive buffer. An overflow bit is set when a message that passed acceptance is ready but its target buffer is still full.

The flag register leaves the block as one vector. The interrupt logic uses the one-cycle `change_o` pulse as its error event. The pulse fires when any counter-derived condition changes, in either direction, and when a new overflow is recorded. Software clears overflow bits through a masked clear strobe; hardware never clears them. Bus-off stays set until the recovery input is pulsed.

Top module: `can_errflag_mon`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `flags_o` and `change_o` are all zero.
- R2: Flag bit 0 (receive warning) is 1 exactly when the receive error count sampled at the previous clock edge is 96 or more. A count of 95 leaves it 0.
- R3: Flag bit 1 (transmit warning) is 1 exactly when the previously sampled transmit count is 96 or more, or `tx_cnt_ovf_i` was 1.
- R4: Flag bit 2 (receive passive) is 1 exactly when the previously sampled receive count is above 127. A count of 127 leaves it 0 and a count of 128 sets it.
- R5: Flag bit 3 (transmit passive) is 1 exactly when the previously sampled transmit count is above 127, or `tx_cnt_ovf_i` was 1.
- R6: Flag bit 4 (bus-off) is set one cycle after `tx_cnt_ovf_i` is 1, meaning the count is above 255. A count of 255 alone does not set it. Once set it stays set, even after the count falls, until a cycle with `busoff_recover_i` high and `tx_cnt_ovf_i` low clears it one cycle later.
- R7: Flag bit 5+i is set one cycle after `msg_ready_i` is high with `msg_buf_i` equal to i while `buf_full_i[i]` is 1. A ready message aimed at a free buffer sets nothing.
- R8: Overflow bits are sticky. Only a cycle with `host_clr_i` high clears them, and it clears only the bits selected by `host_clr_mask_i`. A new overflow in the same cycle wins over the clear.
- R9: `change_o` is high for exactly one cycle, in the same cycle that `flags_o` shows the new value. It fires whenever any of flag bits 0 to 4 differs from the previous cycle, or when an overflow bit goes from 0 to 1. It stays low when flags are steady and when the host clears overflow bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_err_cnt_i | input | 8 | Receive error count |
| tx_err_cnt_i | input | 8 | Transmit error count |
| tx_cnt_ovf_i | input | 1 | Transmit count above 255 |
| msg_ready_i | input | 1 | Accepted message assembled, strobe |
| msg_buf_i | input | IDX_W | Target receive buffer index |
| buf_full_i | input | NUM_BUFS | Per-buffer still-occupied status |
| host_clr_i | input | 1 | Host overflow clear strobe |
| host_clr_mask_i | input | NUM_BUFS | Overflow bits to clear |
| busoff_recover_i | input | 1 | Leaves bus-off state |
| flags_o | output | 5+NUM_BUFS | Flag register |
| change_o | output | 1 | One-cycle error event pulse |

## Verification
Every flag is due exactly one clock edge after the inputs that cause it. `change_o` is due in that same cycle and must drop one edge later if nothing else moves. The bench drives inputs on the falling edge and samples on the next falling edge. This places each check one rising edge after its stimulus, and the check after that confirms the pulse has ended. Each threshold is probed one count below and at the limit. The bus-off hold, masked clears and the set-over-clear collision are each checked in the cycle where they take effect.

// File: rtl/can_efm_pkg.sv
package can_efm_pkg;
  localparam int unsigned CNT_W = 8;
  typedef logic [CNT_W:0] ext_cnt_t;

  localparam ext_cnt_t WARN_LIM    = ext_cnt_t'(96);
  localparam ext_cnt_t PASSIVE_LIM = ext_cnt_t'(127);
  localparam ext_cnt_t BUSOFF_LIM  = ext_cnt_t'(255);

  localparam int unsigned FL_RX_WARN = 0;
  localparam int unsigned FL_TX_WARN = 1;
  localparam int unsigned FL_RX_PASS = 2;
  localparam int unsigned FL_TX_PASS = 3;
  localparam int unsigned FL_BUSOFF  = 4;
  localparam int unsigned NUM_STAT   = 5;

  function automatic ext_cnt_t widen(logic [CNT_W-1:0] cnt, logic ovf);
    return {ovf, cnt};
  endfunction

  function automatic logic reaches(ext_cnt_t v, ext_cnt_t lim);
    return v >= lim;
  endfunction

  function automatic logic exceeds(ext_cnt_t v, ext_cnt_t lim);
    return v > lim;
  endfunction
endpackage

// File: rtl/efm_level_cmp.sv
module efm_level_cmp
  import can_efm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic             tx_ovf_i,
  input  logic             recover_i,
  output logic [NUM_STAT-1:0] stat_o
);
  ext_cnt_t rx_ext_w, tx_ext_w;
  logic busoff_set_w, busoff_clr_w;
  logic [NUM_STAT-1:0] stat_q, stat_d;

  assign rx_ext_w     = widen(rx_cnt_i, 1'b0);
  assign tx_ext_w     = widen(tx_cnt_i, tx_ovf_i);
  assign busoff_set_w = exceeds(tx_ext_w, BUSOFF_LIM);
  assign busoff_clr_w = recover_i && !busoff_set_w;

  always_comb begin
    stat_d             = '0;
    stat_d[FL_RX_WARN] = reaches(rx_ext_w, WARN_LIM);
    stat_d[FL_TX_WARN] = reaches(tx_ext_w, WARN_LIM);
    stat_d[FL_RX_PASS] = exceeds(rx_ext_w, PASSIVE_LIM);
    stat_d[FL_TX_PASS] = exceeds(tx_ext_w, PASSIVE_LIM);
    stat_d[FL_BUSOFF]  = busoff_set_w || (stat_q[FL_BUSOFF] && !busoff_clr_w);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  // R6
  busoff_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovf_i |=> stat_o[FL_BUSOFF]);
  // R6
  busoff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[FL_BUSOFF] && !recover_i) |=> stat_o[FL_BUSOFF]);
  // R3
  tx_ovf_warn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovf_i |=> (stat_o[FL_TX_WARN] && stat_o[FL_TX_PASS]));
  // R4
  rx_pass_warn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[FL_RX_PASS] |-> stat_o[FL_RX_WARN]);
endmodule

// File: rtl/efm_ovf_track.sv
module efm_ovf_track #(
  parameter int unsigned NUM_BUFS = 2,
  parameter int unsigned IDX_W    = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                msg_ready_i,
  input  logic [IDX_W-1:0]    msg_buf_i,
  input  logic [NUM_BUFS-1:0] buf_full_i,
  input  logic                clr_i,
  input  logic [NUM_BUFS-1:0] clr_mask_i,
  output logic [NUM_BUFS-1:0] ovf_o
);
  logic [NUM_BUFS-1:0] hit_w, clr_w, ovf_q;

  for (genvar i = 0; i < NUM_BUFS; i++) begin : g_buf
    assign hit_w[i] = msg_ready_i && (msg_buf_i == IDX_W'(i)) && buf_full_i[i];
    assign clr_w[i] = clr_i && clr_mask_i[i];

    always_ff @(posedge clk_i) begin
      if (!rst_ni) ovf_q[i] <= 1'b0;
      else         ovf_q[i] <= hit_w[i] || (ovf_q[i] && !clr_w[i]);
    end

    // R7
    ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (msg_ready_i && msg_buf_i == IDX_W'(i) && buf_full_i[i]) |=> ovf_o[i]);
    // R8
    ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o[i] && !(clr_i && clr_mask_i[i])) |=> ovf_o[i]);
    // R7
    ovf_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ovf_o[i] && !hit_w[i]) |=> !ovf_o[i]);
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/efm_change_det.sv
module efm_change_det
  import can_efm_pkg::*;
#(
  parameter int unsigned NUM_BUFS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_STAT-1:0] stat_i,
  input  logic [NUM_BUFS-1:0] ovf_i,
  output logic                change_o
);
  logic [NUM_STAT-1:0] stat_prev_q;
  logic [NUM_BUFS-1:0] ovf_prev_q;
  logic stat_moved_w, ovf_new_w;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      stat_prev_q <= '0;
      ovf_prev_q  <= '0;
    end else begin
      stat_prev_q <= stat_i;
      ovf_prev_q  <= ovf_i;
    end
  end

  assign stat_moved_w = |(stat_i ^ stat_prev_q);
  assign ovf_new_w    = |(ovf_i & ~ovf_prev_q);
  assign change_o     = stat_moved_w || ovf_new_w;

  // R9
  change_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_o |-> (!$stable(stat_i) || !$stable(ovf_i)));
  // R9
  change_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stat_i) |-> change_o);
  // R9
  change_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(stat_i) && ((ovf_i & ~$past(ovf_i)) == '0)) |-> !change_o);
endmodule

// File: rtl/can_errflag_mon.sv
module can_errflag_mon
  import can_efm_pkg::*;
#(
  parameter int unsigned NUM_BUFS = 2,
  localparam int unsigned IDX_W  = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int unsigned FLAG_W = NUM_STAT + NUM_BUFS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CNT_W-1:0]    rx_err_cnt_i,
  input  logic [CNT_W-1:0]    tx_err_cnt_i,
  input  logic                tx_cnt_ovf_i,
  input  logic                msg_ready_i,
  input  logic [IDX_W-1:0]    msg_buf_i,
  input  logic [NUM_BUFS-1:0] buf_full_i,
  input  logic                host_clr_i,
  input  logic [NUM_BUFS-1:0] host_clr_mask_i,
  input  logic                busoff_recover_i,
  output logic [FLAG_W-1:0]   flags_o,
  output logic                change_o
);
  logic [NUM_STAT-1:0] stat_w;
  logic [NUM_BUFS-1:0] ovf_w;

  efm_level_cmp level_i (
    .clk_i, .rst_ni,
    .rx_cnt_i (rx_err_cnt_i),
    .tx_cnt_i (tx_err_cnt_i),
    .tx_ovf_i (tx_cnt_ovf_i),
    .recover_i(busoff_recover_i),
    .stat_o   (stat_w)
  );

  efm_ovf_track #(.NUM_BUFS(NUM_BUFS), .IDX_W(IDX_W)) ovf_i (
    .clk_i, .rst_ni,
    .msg_ready_i,
    .msg_buf_i,
    .buf_full_i,
    .clr_i     (host_clr_i),
    .clr_mask_i(host_clr_mask_i),
    .ovf_o     (ovf_w)
  );

  efm_change_det #(.NUM_BUFS(NUM_BUFS)) chg_i (
    .clk_i, .rst_ni,
    .stat_i  (stat_w),
    .ovf_i   (ovf_w),
    .change_o(change_o)
  );

  assign flags_o = {ovf_w, stat_w};

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (flags_o == '0 && !change_o));
endmodule

// File: tb/can_errflag_mon_tb_top.sv
module can_errflag_mon_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rx_cnt = '0, tx_cnt = '0;
  logic tx_ovf = 1'b0, msg_rdy = 1'b0, hclr = 1'b0, recov = 1'b0;
  logic [0:0] mbuf = '0;
  logic [1:0] full = '0, hmask = '0;
  logic [6:0] flags;
  logic chg;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  can_errflag_mon dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_err_cnt_i(rx_cnt), .tx_err_cnt_i(tx_cnt), .tx_cnt_ovf_i(tx_ovf),
    .msg_ready_i(msg_rdy), .msg_buf_i(mbuf), .buf_full_i(full),
    .host_clr_i(hclr), .host_clr_mask_i(hmask), .busoff_recover_i(recov),
    .flags_o(flags), .change_o(chg)
  );

  task automatic chk(string req, logic [6:0] ef, logic ec);
    n_chk++;
    if (flags !== ef || chg !== ec) begin
      n_fail++;
      $display("FAIL %s: flags=%b change=%b expected flags=%b change=%b",
               req, flags, chg, ef, ec);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 in reset", 7'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 after release", 7'b0, 1'b0);
    step(); chk("R1 first cycle", 7'b0, 1'b0);
  endtask

  task automatic t_rx();
    rx_cnt = 8'd95;  step(); chk("R2 rx 95", 7'b0000000, 1'b0);
    rx_cnt = 8'd96;  step(); chk("R2 rx 96", 7'b0000001, 1'b1);
    step(); chk("R9 steady no pulse", 7'b0000001, 1'b0);
    rx_cnt = 8'd127; step(); chk("R4 rx 127", 7'b0000001, 1'b0);
    rx_cnt = 8'd128; step(); chk("R4 rx 128", 7'b0000101, 1'b1);
    rx_cnt = 8'd0;   step(); chk("R9 falling pulse", 7'b0000000, 1'b1);
    step(); chk("R9 pulse ends", 7'b0000000, 1'b0);
  endtask

  task automatic t_tx();
    tx_cnt = 8'd95;  step(); chk("R3 tx 95", 7'b0000000, 1'b0);
    tx_cnt = 8'd96;  step(); chk("R3 tx 96", 7'b0000010, 1'b1);
    tx_cnt = 8'd127; step(); chk("R5 tx 127", 7'b0000010, 1'b0);
    tx_cnt = 8'd128; step(); chk("R5 tx 128", 7'b0001010, 1'b1);
    tx_cnt = 8'd0;   step(); chk("R5 tx back", 7'b0000000, 1'b1);
  endtask

  task automatic t_busoff();
    tx_cnt = 8'd255; step(); chk("R6 255 no busoff", 7'b0001010, 1'b1);
    tx_ovf = 1'b1; tx_cnt = 8'd0; step(); chk("R6 busoff set", 7'b0011010, 1'b1);
    tx_ovf = 1'b0; tx_cnt = 8'd200; step(); chk("R6 busoff held", 7'b0011010, 1'b0);
    tx_cnt = 8'd0; step(); chk("R6 busoff held low cnt", 7'b0010000, 1'b1);
    step(); chk("R6 still held", 7'b0010000, 1'b0);
    recov = 1'b1; step(); chk("R6 recovery", 7'b0000000, 1'b1);
    recov = 1'b0; step(); chk("R6 stays clear", 7'b0000000, 1'b0);
  endtask

  task automatic t_ovf();
    full = 2'b10; msg_rdy = 1'b1; mbuf = 1'b0;
    step(); chk("R7 free buffer", 7'b0000000, 1'b0);
    mbuf = 1'b1; step(); chk("R7 full buffer 1", 7'b1000000, 1'b1);
    msg_rdy = 1'b0; step(); chk("R8 sticky", 7'b1000000, 1'b0);
    msg_rdy = 1'b1; step(); chk("R9 repeat not new", 7'b1000000, 1'b0);
    full = 2'b01; mbuf = 1'b0; step(); chk("R7 full buffer 0", 7'b1100000, 1'b1);
    msg_rdy = 1'b0; hclr = 1'b1; hmask = 2'b10;
    step(); chk("R8 masked clear, R9 no pulse", 7'b0100000, 1'b0);
    hmask = 2'b01; msg_rdy = 1'b1;
    step(); chk("R8 set wins over clear", 7'b0100000, 1'b0);
    msg_rdy = 1'b0; step(); chk("R8 clear", 7'b0000000, 1'b0);
    hclr = 1'b0; hmask = 2'b00; full = 2'b00;
    step(); chk("R8 stays clear", 7'b0000000, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_rx();
    t_tx();
    t_busoff();
    t_ovf();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule